// File: doc/BRIEF.md
# SPI Master Clock and Framing Engine

This block runs one serial frame at a time as the master of an SPI link. A 32-bit attribute word sets the frame length, the clock's resting level, which clock edge launches data and which one captures it, the bit order, and the SCK rate. The rate comes from a two-bit prescaler and a four-bit scaler. A double-rate bit halves the division, which allows odd ratios. The word sits in a register that is written through a write strobe. The engine copies the word when a transfer starts, so the word can be rewritten while a frame is in flight without upsetting it.

A transfer begins with a one-cycle start pulse and a parallel transmit word. The engine raises busy, drives SCK and MOSI, and captures MISO into a parallel receive word. When it finishes, it pulses done. The word also holds chip-select delay fields, which are stored but have no effect. A separate continuous-clock request input is only checked for legality: `cfgError` is raised whenever that request could not be honoured with the current attributes.

Top module: `spi_master_engine`

## Requirements
- R1: After reset the attribute register reads as frame-size field 15 with every other field zero. A transfer started without any write is therefore 16 bits, MSB first, with SCK resting low, phase 0 and a divisor of 4. After reset busy, done and rxData are 0.
- R2: Field positions, with word bit 31 written as attribute bit 0: [31] double-rate, [30:27] frame size, [26] polarity, [25] phase, [24] LSB-first, [17:16] baud prescaler, [3:0] baud scaler. Bits [23:18] and [15:4] are stored and have no effect.
- R3: A frame has frame-size + 1 bits, and a frame-size value below 3 gives a 4-bit frame. Each frame makes exactly two SCK edges per bit.
- R4: SCK rests low when polarity is 0 and high when polarity is 1, both between transfers and in the cycle done is high.
- R5: With phase 0, MISO is captured on each leading SCK edge and MOSI moves to the next bit on each trailing edge. The first bit is on MOSI before the first leading edge.
- R6: With phase 1, MOSI takes each bit on a leading SCK edge and MISO is captured on the following trailing edge.
- R7: With LSB-first 0, the k-th bit on the wire is txData[N-1-k], and the k-th captured bit goes to rxData[N-1-k]. With LSB-first 1, both use bit k. rxData bits at N and above are 0. txData bits at N and above are never sent.
- R8: The divisor D is P×S. P is 2, 3, 5 or 7 for prescaler codes 0 to 3. S is 2, 4, 6 or 8 for scaler codes 0 to 3, and 16·2^(code−4) for codes 4 to 15. With double-rate 0, SCK spends D/2 system clocks in each half.
- R9: With double-rate 1, D is halved. The half from leading to trailing edge lasts floor(D/2) clocks with phase 0 and ceil(D/2) with phase 1; the other half takes the rest. The first leading edge comes one resting half after the start cycle.
- R10: cfgError is high exactly when the continuous-clock request is high and either the phase is 0 or D is 2 or 3.
- R11: busy rises in the cycle after start is accepted. A start while busy is ignored. An attribute write during a transfer only affects later transfers.
- R12: done is a one-cycle pulse. It arrives in the cycle SCK returns to rest after the final edge. In that cycle busy is low and rxData holds the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| attrWe | input | 1 | Attribute register write strobe |
| attrIn | input | 32 | Attribute word to store |
| contSck | input | 1 | Continuous-clock request (legality check only) |
| start | input | 1 | Start one frame |
| txData | input | 16 | Parallel transmit word, right-aligned |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rxData | output | 16 | Last received frame, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cfgError | output | 1 | Illegal continuous-clock request |

## Verification
The bench uses the default package parameters: 16-bit maximum frame and an 18-bit half-period counter. With these, every frame length from the clamped 4 bits to 16 bits can be reached, as can divisors from 2 up to the prescaler-7 range. The bench selects divisors 3, 4, 6, 8, 10 and 112. This exercises the uneven double-rate split in both phases and a long slow clock alongside the fastest ones. MISO is tied to the inverse of MOSI, so a correct received word is the complement of the transmitted bits in the same order.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  parameter int MAX_FRAME = 16;
  parameter int CNT_W     = 18;
  localparam int IDX_W  = $clog2(MAX_FRAME + 1);
  localparam int BIT_W  = $clog2(MAX_FRAME);
  localparam int EDGE_W = IDX_W + 1;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic [IDX_W-1:0] frameLen;
    logic [CNT_W-1:0] activeLen;
    logic [CNT_W-1:0] idleLen;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic drive;
    logic sample;
    logic step;
    logic finish;
  } strobe_t;

  function automatic logic [CNT_W-1:0] sckDivisor(input logic dbr,
                                                  input logic [1:0] pbr,
                                                  input logic [3:0] br);
    logic [CNT_W-1:0] pre, sc, prod;
    case (pbr)
      2'd0: pre = CNT_W'(2);
      2'd1: pre = CNT_W'(3);
      2'd2: pre = CNT_W'(5);
      default: pre = CNT_W'(7);
    endcase
    if (br < 4'd4) sc = CNT_W'({br, 1'b0}) + CNT_W'(2);
    else           sc = CNT_W'(16) << (br - 4'd4);
    prod = pre * sc;
    return dbr ? (prod >> 1) : prod;
  endfunction

  function automatic cfg_t decodeCfg(input logic dbr, input logic [3:0] fs,
                                     input logic cpol, input logic cpha,
                                     input logic [1:0] pbr, input logic [3:0] br);
    cfg_t c;
    logic [CNT_W-1:0] div;
    div = sckDivisor(dbr, pbr, br);
    c.cpol = cpol;
    c.cpha = cpha;
    c.frameLen = (fs < 4'd3) ? IDX_W'(4) : IDX_W'(fs) + IDX_W'(1);
    c.activeLen = cpha ? (div - (div >> 1)) : (div >> 1);
    c.idleLen = div - c.activeLen;
    return c;
  endfunction
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  cfg_t    cfgIn,
  output cfg_t    cfgLat,
  output logic    running,
  output logic    sckAct,
  output strobe_t strb
);
  logic [CNT_W-1:0]  cnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic tick, leading, lastEdge;

  assign tick     = running && (cnt == '0);
  assign leading  = ~edgeCnt[0];
  assign lastEdge = (edgeCnt == ({cfgLat.frameLen, 1'b0} - EDGE_W'(1)));

  always_comb begin
    strb.load   = start && !running;
    strb.sample = tick && (leading ^ cfgLat.cpha);
    strb.drive  = tick && (cfgLat.cpha ? leading : !leading);
    strb.step   = tick && !leading;
    strb.finish = tick && lastEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      edgeCnt <= '0;
      sckAct  <= 1'b0;
      cfgLat  <= '0;
    end else if (strb.load) begin
      running <= 1'b1;
      cfgLat  <= cfgIn;
      cnt     <= cfgIn.idleLen - CNT_W'(1);
      edgeCnt <= '0;
      sckAct  <= 1'b0;
    end else if (tick) begin
      sckAct  <= ~sckAct;
      edgeCnt <= edgeCnt + EDGE_W'(1);
      cnt     <= (leading ? cfgLat.activeLen : cfgLat.idleLen) - CNT_W'(1);
      if (lastEdge) running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R3: edge count stays inside two edges per bit
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (edgeCnt < {cfgLat.frameLen, 1'b0}));

  // R11: the copied attributes hold for the whole frame
  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> $stable(cfgLat));

  // R3: the frame ends with SCK back at rest
  a_r3_end_at_rest: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (!running && !sckAct));
endmodule

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 loadLsb,
  input  logic [IDX_W-1:0]     loadLen,
  input  logic [MAX_FRAME-1:0] txData,
  input  logic                 miso,
  output logic                 mosi,
  output logic [MAX_FRAME-1:0] rxData,
  output logic                 done
);
  logic [MAX_FRAME-1:0] txLat, rxAcc, rxNext;
  logic                 lsbLat;
  logic [IDX_W-1:0]     lenLat, k, kNext;
  logic [BIT_W-1:0]     curIdx, driveIdx, firstIdx;

  function automatic logic [BIT_W-1:0] idxOf(input logic [IDX_W-1:0] kk,
                                             input logic lsb,
                                             input logic [IDX_W-1:0] len);
    return BIT_W'(lsb ? kk : (len - IDX_W'(1) - kk));
  endfunction

  assign kNext    = k + IDX_W'(strb.step);
  assign curIdx   = idxOf(k, lsbLat, lenLat);
  assign driveIdx = idxOf(kNext, lsbLat, lenLat);
  assign firstIdx = idxOf('0, loadLsb, loadLen);

  always_comb begin
    rxNext = rxAcc;
    if (strb.sample) rxNext[curIdx] = miso;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLat  <= '0;
      rxAcc  <= '0;
      rxData <= '0;
      lsbLat <= 1'b0;
      lenLat <= '0;
      k      <= '0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        txLat  <= txData;
        lsbLat <= loadLsb;
        lenLat <= loadLen;
        k      <= '0;
        rxAcc  <= '0;
        mosi   <= txData[firstIdx];
      end else begin
        rxAcc <= rxNext;
        if (strb.step) k <= kNext;
        if (strb.drive && (kNext < lenLat)) mosi <= txLat[driveIdx];
        if (strb.finish) rxData <= rxNext;
      end
    end
  end

  // R5 / R6: launch and capture never share an SCK edge
  a_r5_launch_capture_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sample && strb.drive));

  // R3: bit index never runs past the frame
  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    k <= lenLat);

  // R12: done lasts a single cycle
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        attrWe,
  input  logic [31:0] attrIn,
  input  logic        contSck,
  input  logic        start,
  input  logic [15:0] txData,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [15:0] rxData,
  output logic        sck,
  output logic        mosi,
  output logic        cfgError
);
  localparam logic [31:0] ATTR_RESET = 32'h7800_0000;

  logic [31:0]      attrReg;
  cfg_t             cfgIn, cfgLat;
  strobe_t          strb;
  logic             running, sckAct;
  logic [CNT_W-1:0] divNow;
  logic             unusedDelayBits;

  always_ff @(posedge clk) begin
    if (!rstN)       attrReg <= ATTR_RESET;
    else if (attrWe) attrReg <= attrIn;
  end

  assign unusedDelayBits = ^{attrReg[23:18], attrReg[15:4]};
  assign cfgIn  = decodeCfg(attrReg[31], attrReg[30:27], attrReg[26],
                            attrReg[25], attrReg[17:16], attrReg[3:0]);
  assign divNow = sckDivisor(attrReg[31], attrReg[17:16], attrReg[3:0]);
  assign cfgError = contSck &&
                    (!cfgIn.cpha || divNow == CNT_W'(2) || divNow == CNT_W'(3));

  spi_eng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgIn(cfgIn),
    .cfgLat(cfgLat), .running(running), .sckAct(sckAct), .strb(strb)
  );

  spi_eng_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadLsb(attrReg[24]), .loadLen(cfgIn.frameLen),
    .txData(txData), .miso(miso),
    .mosi(mosi), .rxData(rxData), .done(done)
  );

  assign busy = running;
  assign sck  = running ? (cfgLat.cpol ^ sckAct) : cfgIn.cpol;
endmodule

// File: tb/spi_master_engine_tb.sv
module spi_master_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        attrWe = 1'b0;
  logic [31:0] attrIn = '0;
  logic        contSck = 1'b0;
  logic        start = 1'b0;
  logic [15:0] txData = '0;
  logic        miso;
  logic        busy, done, sck, mosi, cfgError;
  logic [15:0] rxData;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_master_engine u_dut (
    .clk(clk), .rstN(rstN), .attrWe(attrWe), .attrIn(attrIn),
    .contSck(contSck), .start(start), .txData(txData), .miso(miso),
    .busy(busy), .done(done), .rxData(rxData), .sck(sck), .mosi(mosi),
    .cfgError(cfgError)
  );

  typedef struct {
    logic [15:0] tx;
    int n, act, idl;
    logic lsb, cpol, cpha, dbr;
  } item_t;

  item_t q[$];
  item_t cur;
  int total = 0, bad = 0, cyc = 0, doneCnt = 0;
  logic [31:0] curAttr = 32'h7800_0000;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit dbr, input int fs, input bit cpol,
                                     input bit cpha, input bit lsb, input int pbr,
                                     input int br);
    return {dbr, 4'(fs), cpol, cpha, lsb, 6'h2A, 2'(pbr), 12'hC35, 4'(br)};
  endfunction

  function automatic int divOf(input logic [31:0] w);
    int p, s, d;
    p = (w[17:16] == 0) ? 2 : (w[17:16] == 1) ? 3 : (w[17:16] == 2) ? 5 : 7;
    s = (w[3:0] < 4) ? 2 * (int'(w[3:0]) + 1) : (16 << (int'(w[3:0]) - 4));
    d = p * s;
    return w[31] ? d / 2 : d;
  endfunction

  function automatic item_t mkItem(input logic [31:0] w, input logic [15:0] tx);
    item_t it;
    int d;
    d = divOf(w);
    it.tx = tx;
    it.n = (w[30:27] < 3) ? 4 : int'(w[30:27]) + 1;
    it.cpol = w[26]; it.cpha = w[25]; it.lsb = w[24]; it.dbr = w[31];
    it.act = it.cpha ? (d + 1) / 2 : d / 2;
    it.idl = d - it.act;
    return it;
  endfunction

  task automatic setAttr(input logic [31:0] w);
    @(negedge clk); attrWe = 1'b1; attrIn = w;
    @(negedge clk); attrWe = 1'b0;
    curAttr = w;
  endtask

  task automatic pulseStart(input logic [15:0] tx);
    @(negedge clk); start = 1'b1; txData = tx;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic doXfer(input logic [15:0] tx);
    q.push_back(mkItem(curAttr, tx));
    pulseStart(tx);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor and scoreboard
  logic prevSck = 1'b0, prevBusy = 1'b0, prevDone = 1'b0, active = 1'b0;
  logic [15:0] gotTx;
  int tLast, edges, kb, durBad;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (busy && !prevBusy) begin
        if (q.size() == 0) begin
          chk(0, "R11", "start accepted while busy", 1, 0);
          active = 1'b0;
        end else begin
          cur = q[0]; active = 1'b1;
        end
        tLast = cyc; edges = 0; kb = 0; gotTx = '0; durBad = 0;
      end
      if (active && sck != prevSck) begin
        bit lead;
        lead = (prevSck == cur.cpol);
        if ((cyc - tLast) != (lead ? cur.idl : cur.act)) durBad++;
        tLast = cyc;
        edges++;
        if (lead != cur.cpha) begin
          if (kb < cur.n) gotTx[cur.lsb ? kb : cur.n - 1 - kb] = mosi;
          kb++;
        end
      end
      if (done) begin
        logic [15:0] mask;
        doneCnt++;
        chk(!prevDone, "R12", "done wider than one cycle", 1, 0);
        chk(!busy, "R12", "busy low with done", busy, 0);
        if (active) begin
          mask = 16'((17'd1 << cur.n) - 17'd1);
          void'(q.pop_front());
          chk(gotTx == (cur.tx & mask), cur.cpha ? "R6/R7" : "R5/R7",
              "wire bits", gotTx, cur.tx & mask);
          chk(rxData == (~cur.tx & mask), "R7", "rxData", rxData, ~cur.tx & mask);
          chk(edges == 2 * cur.n, "R3", "SCK edges", edges, 2 * cur.n);
          chk(durBad == 0, cur.dbr ? "R9" : "R8", "half-period lengths", durBad, 0);
          chk(sck == cur.cpol, "R4", "SCK rest at done", sck, cur.cpol);
          active = 1'b0;
        end else begin
          chk(0, "R11", "done with no queued transfer", 1, 0);
        end
      end
      prevSck = sck; prevBusy = busy; prevDone = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(rxData == 16'h0, "R1", "rxData after reset", rxData, 0);
    chk(sck == 1'b0, "R1", "SCK rest after reset", sck, 0);
    chk(!cfgError, "R10", "no request no error", cfgError, 0);
    // R1: default attributes: 16 bits, MSB first, divisor 4
    doXfer(16'hA5C3);
    // R2 R4 R5: polarity 1 phase 0, 8 bits, upper tx bits not sent
    setAttr(mk(0, 7, 1, 0, 0, 0, 0));
    chk(sck == 1'b1, "R4", "SCK rest high", sck, 1);
    doXfer(16'hFF96);
    // R6 R7: phase 1, 5 bits, LSB first, divisor 6
    setAttr(mk(0, 4, 0, 1, 1, 1, 0));
    chk(sck == 1'b0, "R4", "SCK rest low", sck, 0);
    doXfer(16'h0013);
    // R6 R7: polarity 1 phase 1, 16 bits LSB first, divisor 8
    setAttr(mk(0, 15, 1, 1, 1, 0, 1));
    doXfer(16'h1234);
    // R3: frame-size 1 clamps to 4 bits
    setAttr(mk(0, 1, 0, 0, 0, 0, 0));
    doXfer(16'hFF0B);
    // R9: double rate, divisor 3, phase 0 then phase 1
    setAttr(mk(1, 9, 0, 0, 0, 1, 0));
    doXfer(16'h02D1);
    setAttr(mk(1, 9, 1, 1, 1, 1, 0));
    doXfer(16'h0155);
    // R9: double rate divisor 10 (even split)
    setAttr(mk(1, 5, 0, 1, 0, 2, 1));
    doXfer(16'h0029);
    // R8: prescaler 7, scaler code 4: divisor 112
    setAttr(mk(0, 3, 0, 0, 0, 3, 4));
    doXfer(16'h0006);
    // R10: continuous-clock legality
    contSck = 1'b1;
    setAttr(mk(0, 7, 0, 0, 0, 0, 0));
    chk(cfgError == 1'b1, "R10", "phase 0 request", cfgError, 1);
    setAttr(mk(0, 7, 0, 1, 0, 1, 0));
    chk(cfgError == 1'b0, "R10", "phase 1 divisor 6", cfgError, 0);
    setAttr(mk(1, 7, 0, 1, 0, 1, 0));
    chk(cfgError == 1'b1, "R10", "divisor 3", cfgError, 1);
    setAttr(mk(1, 7, 0, 1, 0, 0, 0));
    chk(cfgError == 1'b1, "R10", "divisor 2", cfgError, 1);
    setAttr(mk(0, 7, 0, 1, 0, 0, 0));
    chk(cfgError == 1'b0, "R10", "phase 1 divisor 4", cfgError, 0);
    contSck = 1'b0;
    setAttr(mk(0, 7, 0, 0, 0, 0, 0));
    chk(cfgError == 1'b0, "R10", "request low", cfgError, 0);
    // R11: start while busy ignored; attribute write mid-frame deferred
    setAttr(mk(0, 7, 0, 0, 0, 0, 1));
    q.push_back(mkItem(curAttr, 16'h00C4));
    pulseStart(16'h00C4);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R11", "busy during frame", busy, 1);
    pulseStart(16'h003B);
    setAttr(mk(0, 3, 0, 0, 0, 0, 0));
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(q.size() == 0 && !busy, "R11", "no extra frame", q.size(), 0);
    chk(doneCnt == 10, "R11", "done count", doneCnt, 10);
    // R11: the deferred write now applies (4 bits)
    doXfer(16'h000D);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule